// File: doc/BRIEF.md
# Power-Management Configuration and I/O Window Decoder

This block holds the few configuration-space registers of a chipset power-management function that decide where its I/O resources sit. It turns them into address decode. Dword-wide configuration writes, each with byte enables, set the base and the enable of two relocatable 64-byte I/O windows. One window carries the power-management registers and the other carries the SMBus controller. Each incoming I/O request is compared against both windows and against a fixed 4-byte general-purpose-event window. The block then raises one combinational hit strobe per window.

The block also acts on the APM control port. Two command values work as an ACPI on/off switch that drives the SCI enable output. Every other command value becomes a one-cycle SMI request pulse, but only while software has enabled SMI generation in configuration space. Each write that lands in the general-purpose-event window produces a pulse telling the event logic to re-evaluate its SCI level. That event logic, the timer and the SMBus controller sit outside this block.

Top module: `pmcfg_decoder`

## Requirements
- R1: After synchronous reset, readback gives the following dwords: 0x00000001 at dword 0x10 (bytes 0x40–0x43), 0x00000000 at dword 0x16 (bytes 0x58–0x5b, or 0x02000000 when SMM_SUPPORTED is 0), 0x00000000 at dword 0x20 (byte 0x80), SMB_BASE_RST|1 at dword 0x24 (bytes 0x90–0x93) and 0x00090000 at dword 0x34 (byte 0xd2 = 0x09). sci_en and smi_pulse are both 0. Readback returns on cfg_rdata one clock after cfg_rdw is presented, and any dword not listed reads as 0 and ignores writes.
- R2: hit_pm is 1 exactly when io_valid is 1, bit 0 of byte 0x80 is 1, and io_addr[15:6] equals bits [15:6] of the 16-bit little-endian value in bytes 0x40–0x41. This gives a 64-byte window aligned to 64 bytes.
- R3: Bit 0 of byte 0x40 always reads back as 1, whatever value is written. The other written bits read back as written.
- R4: hit_smb is 1 exactly when io_valid is 1, bit 0 of byte 0xd2 (cfg_rdata bit 16 of dword 0x34) is 1, and io_addr[15:6] equals bits [15:6] of bytes 0x90–0x91. After reset the window is enabled at SMB_BASE_RST.
- R5: A configuration write changes only the bytes whose enables are set. The window decode follows the new bytes from the second rising edge after the write edge, and it does not change while no write touches the base or enable bytes.
- R6: hit_gpe is 1 exactly when io_valid is 1 and io_addr lies in 0xafe0–0xafe3. No enable gates this window.
- R7: An APM write of 0xf1 sets sci_en and an APM write of 0xf0 clears it, each from the next rising edge. Neither value produces an SMI pulse.
- R8: An APM write of any other value raises smi_pulse for exactly one cycle after the write edge if bit 1 of byte 0x5b (bit 25 of dword 0x16) is 1. Otherwise it produces no pulse, and it leaves sci_en unchanged.
- R9: sci_reeval pulses for one cycle after every edge at which io_valid, io_write and hit_gpe are all 1. Reads of that window produce no pulse.
- R10: With io_valid at 0, all three hit strobes are 0 whatever io_addr holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index of the write (byte offset / 4) |
| cfg_be | input | 4 | Byte enables, bit n selects byte lane n |
| cfg_wdata | input | 32 | Little-endian write data |
| cfg_rdw | input | 6 | Dword index for readback |
| cfg_rdata | output | 32 | Registered readback data |
| io_valid | input | 1 | I/O request valid |
| io_write | input | 1 | I/O request is a write |
| io_addr | input | 16 | I/O address |
| hit_pm | output | 1 | Power-management window hit |
| hit_smb | output | 1 | SMBus window hit |
| hit_gpe | output | 1 | Event window hit |
| sci_reeval | output | 1 | Pulse after a write into the event window |
| apm_we | input | 1 | APM control-port write strobe |
| apm_data | input | 8 | APM command value |
| sci_en | output | 1 | ACPI SCI enable state |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
Directed probes hit the first and last byte of each window and the bytes just outside it. They do this before and after relocation, with the enables on and off, and with io_valid low. This separates an off-by-one in the window length from a wrong base or a missing enable gate. Partial-byte-enable writes show whether untouched bytes keep their values and whether writes to other dwords leave the decode alone. The APM port is driven with 0xf1, with 0xf0 and with other values, both with the SMI gate open and closed. Constrained random writes, probes biased toward window edges and random commands are then compared against a byte-level model of the registers.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;

  localparam int NSLOT = 5;
  localparam int DW_AW = 6;

  // implemented dword slots
  localparam int SL_PMBASE  = 0;  // bytes 0x40..0x43
  localparam int SL_SMICTL  = 1;  // bytes 0x58..0x5b
  localparam int SL_PMCTL   = 2;  // bytes 0x80..0x83
  localparam int SL_SMBBASE = 3;  // bytes 0x90..0x93
  localparam int SL_SMBCTL  = 4;  // bytes 0xd0..0xd3

  localparam logic [DW_AW-1:0] DW_PMBASE  = 6'h10;
  localparam logic [DW_AW-1:0] DW_SMICTL  = 6'h16;
  localparam logic [DW_AW-1:0] DW_PMCTL   = 6'h20;
  localparam logic [DW_AW-1:0] DW_SMBBASE = 6'h24;
  localparam logic [DW_AW-1:0] DW_SMBCTL  = 6'h34;

  localparam logic [7:0] APM_ON  = 8'hf1;
  localparam logic [7:0] APM_OFF = 8'hf0;

  typedef enum logic [1:0] {
    APM_CMD_ON  = 2'd0,
    APM_CMD_OFF = 2'd1,
    APM_CMD_SMI = 2'd2
  } apm_cls_e;

  function automatic int slot_of(input logic [DW_AW-1:0] dw);
    case (dw)
      DW_PMBASE:  return SL_PMBASE;
      DW_SMICTL:  return SL_SMICTL;
      DW_PMCTL:   return SL_PMCTL;
      DW_SMBBASE: return SL_SMBBASE;
      DW_SMBCTL:  return SL_SMBCTL;
      default:    return -1;
    endcase
  endfunction

  function automatic apm_cls_e apm_class(input logic [7:0] v);
    if (v == APM_ON)  return APM_CMD_ON;
    if (v == APM_OFF) return APM_CMD_OFF;
    return APM_CMD_SMI;
  endfunction

endpackage

// File: rtl/pmcfg_regs.sv
module pmcfg_regs
  import pmcfg_pkg::*;
#(
  parameter int          IO_AW         = 16,
  parameter int          WIN_LOG2      = 6,
  parameter bit          SMM_SUPPORTED = 1'b1,
  parameter logic [15:0] SMB_BASE_RST  = 16'hb100
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [DW_AW-1:0]          cfg_dw,
  input  logic [3:0]                cfg_be,
  input  logic [31:0]               cfg_wdata,
  input  logic [DW_AW-1:0]          cfg_rdw,
  output logic [31:0]               cfg_rdata,
  output logic [IO_AW-1:WIN_LOG2]   pm_base,
  output logic                      pm_en,
  output logic [IO_AW-1:WIN_LOG2]   smb_base,
  output logic                      smb_en,
  output logic                      smi_en
);

  logic [NSLOT-1:0][31:0] q_all;

  function automatic logic [31:0] rst_val(input int s);
    case (s)
      SL_PMBASE:  return 32'h0000_0001;
      SL_SMICTL:  return SMM_SUPPORTED ? 32'h0000_0000 : 32'h0200_0000;
      SL_SMBBASE: return {16'h0000, SMB_BASE_RST | 16'h0001};
      SL_SMBCTL:  return 32'h0009_0000;
      default:    return 32'h0000_0000;
    endcase
  endfunction

  // one storage dword per implemented slot, byte-lane writes
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic        sel;
    logic [31:0] q, d;
    assign sel = cfg_we && (slot_of(cfg_dw) == s);
    always_comb begin
      d = q;
      for (int b = 0; b < 4; b++)
        if (sel && cfg_be[b]) d[8*b +: 8] = cfg_wdata[8*b +: 8];
      if (s == SL_PMBASE) d[0] = 1'b1;  // read-only indicator bit
    end
    always_ff @(posedge clk) begin
      if (rst) q <= rst_val(s);
      else     q <= d;
    end
    assign q_all[s] = q;
  end

  // touch detection, registered so decode is rebuilt from stored bytes
  logic touch_pm_q, touch_smb_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      touch_pm_q  <= 1'b0;
      touch_smb_q <= 1'b0;
    end else begin
      touch_pm_q  <= cfg_we && (((slot_of(cfg_dw) == SL_PMBASE) && (|cfg_be)) ||
                                ((slot_of(cfg_dw) == SL_PMCTL)  && cfg_be[0]));
      touch_smb_q <= cfg_we && (((slot_of(cfg_dw) == SL_SMBBASE) && (|cfg_be)) ||
                                ((slot_of(cfg_dw) == SL_SMBCTL)  && cfg_be[2]));
    end
  end

  localparam logic [15:0] PM_RST_BASE = 16'h0001;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_base  <= PM_RST_BASE[IO_AW-1:WIN_LOG2];
      pm_en    <= 1'b0;
      smb_base <= SMB_BASE_RST[IO_AW-1:WIN_LOG2];
      smb_en   <= 1'b1;
    end else begin
      if (touch_pm_q) begin
        pm_base <= q_all[SL_PMBASE][IO_AW-1:WIN_LOG2];
        pm_en   <= q_all[SL_PMCTL][0];
      end
      if (touch_smb_q) begin
        smb_base <= q_all[SL_SMBBASE][IO_AW-1:WIN_LOG2];
        smb_en   <= q_all[SL_SMBCTL][16];
      end
    end
  end

  assign smi_en = q_all[SL_SMICTL][25];

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (slot_of(cfg_rdw))
        SL_PMBASE:  cfg_rdata <= q_all[SL_PMBASE];
        SL_SMICTL:  cfg_rdata <= q_all[SL_SMICTL];
        SL_PMCTL:   cfg_rdata <= q_all[SL_PMCTL];
        SL_SMBBASE: cfg_rdata <= q_all[SL_SMBBASE];
        SL_SMBCTL:  cfg_rdata <= q_all[SL_SMBCTL];
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  // R3: indicator bit always seen by software
  p_pmbase_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdw == DW_PMBASE) |=> cfg_rdata[0]);

  // R5: decode holds while no write could have touched it
  p_decode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !$past(cfg_we)) |=>
      ($stable(pm_base) && $stable(pm_en) && $stable(smb_base) && $stable(smb_en)));

endmodule

// File: rtl/pmcfg_window.sv
module pmcfg_window #(
  parameter int AW  = 16,
  parameter int LEN = 64
) (
  input  logic          valid,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  localparam logic [AW-1:0] LEN_V = AW'(LEN);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - base;
    hit = valid && en && (off < LEN_V);
  end

endmodule

// File: rtl/pmcfg_apm.sv
module pmcfg_apm
  import pmcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       apm_we,
  input  logic [7:0] apm_data,
  input  logic       smi_en,
  output logic       sci_en,
  output logic       smi_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_en    <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      smi_pulse <= 1'b0;
      if (apm_we) begin
        case (apm_class(apm_data))
          APM_CMD_ON:  sci_en    <= 1'b1;
          APM_CMD_OFF: sci_en    <= 1'b0;
          default:     smi_pulse <= smi_en;
        endcase
      end
    end
  end

  // R7
  p_sci_set_r7: assert property (@(posedge clk) disable iff (rst)
    (apm_we && apm_data == APM_ON) |=> (sci_en && !smi_pulse));
  p_sci_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (apm_we && apm_data == APM_OFF) |=> (!sci_en && !smi_pulse));

  // R8
  p_smi_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (apm_we && apm_data != APM_ON && apm_data != APM_OFF) |=>
      (smi_pulse == $past(smi_en) && $stable(sci_en)));
  p_smi_single_r8: assert property (@(posedge clk) disable iff (rst)
    !apm_we |=> !smi_pulse);

endmodule

// File: rtl/pmcfg_decoder.sv
module pmcfg_decoder
  import pmcfg_pkg::*;
#(
  parameter int          IO_AW         = 16,
  parameter int          WIN_LOG2      = 6,
  parameter bit          SMM_SUPPORTED = 1'b1,
  parameter logic [15:0] SMB_BASE_RST  = 16'hb100,
  parameter logic [15:0] GPE_BASE      = 16'hafe0,
  parameter int          GPE_LEN       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_dw,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  input  logic [5:0]       cfg_rdw,
  output logic [31:0]      cfg_rdata,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  output logic             hit_pm,
  output logic             hit_smb,
  output logic             hit_gpe,
  output logic             sci_reeval,
  input  logic             apm_we,
  input  logic [7:0]       apm_data,
  output logic             sci_en,
  output logic             smi_pulse
);

  localparam int WIN_LEN = 1 << WIN_LOG2;

  logic [IO_AW-1:WIN_LOG2] pm_base, smb_base;
  logic                    pm_en, smb_en, smi_en;

  pmcfg_regs #(
    .IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2),
    .SMM_SUPPORTED(SMM_SUPPORTED), .SMB_BASE_RST(SMB_BASE_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdw(cfg_rdw), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .pm_en(pm_en),
    .smb_base(smb_base), .smb_en(smb_en),
    .smi_en(smi_en)
  );

  pmcfg_window #(.AW(IO_AW), .LEN(WIN_LEN)) u_win_pm (
    .valid(io_valid), .en(pm_en), .base({pm_base, {WIN_LOG2{1'b0}}}),
    .addr(io_addr), .hit(hit_pm)
  );

  pmcfg_window #(.AW(IO_AW), .LEN(WIN_LEN)) u_win_smb (
    .valid(io_valid), .en(smb_en), .base({smb_base, {WIN_LOG2{1'b0}}}),
    .addr(io_addr), .hit(hit_smb)
  );

  pmcfg_window #(.AW(IO_AW), .LEN(GPE_LEN)) u_win_gpe (
    .valid(io_valid), .en(1'b1), .base(GPE_BASE[IO_AW-1:0]),
    .addr(io_addr), .hit(hit_gpe)
  );

  always_ff @(posedge clk) begin
    if (rst) sci_reeval <= 1'b0;
    else     sci_reeval <= io_valid && io_write && hit_gpe;
  end

  pmcfg_apm u_apm (
    .clk(clk), .rst(rst),
    .apm_we(apm_we), .apm_data(apm_data), .smi_en(smi_en),
    .sci_en(sci_en), .smi_pulse(smi_pulse)
  );

  // R2 / R4: relocatable windows never hit while disabled
  p_pm_gated_r2: assert property (@(posedge clk) disable iff (rst)
    hit_pm |-> pm_en);
  p_smb_gated_r4: assert property (@(posedge clk) disable iff (rst)
    hit_smb |-> smb_en);

  // R9
  p_gpe_eval_r9: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && hit_gpe) |=> sci_reeval);
  p_gpe_read_r9: assert property (@(posedge clk) disable iff (rst)
    !io_write |=> !sci_reeval);

  // R10
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !io_valid |-> !(hit_pm || hit_smb || hit_gpe));

endmodule

// File: tb/pmcfg_decoder_test.sv
module pmcfg_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_rdw = '0;
  logic [31:0] cfg_rdata;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic        hit_pm, hit_smb, hit_gpe, sci_reeval;
  logic        apm_we = 1'b0;
  logic [7:0]  apm_data = '0;
  logic        sci_en, smi_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmcfg_decoder uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdw(cfg_rdw), .cfg_rdata(cfg_rdata),
    .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .hit_pm(hit_pm), .hit_smb(hit_smb), .hit_gpe(hit_gpe), .sci_reeval(sci_reeval),
    .apm_we(apm_we), .apm_data(apm_data), .sci_en(sci_en), .smi_pulse(smi_pulse)
  );

  // byte-level model
  logic [31:0] m [5];
  logic        sci_m;
  localparam logic [5:0] DWS [5] = '{6'h10, 6'h16, 6'h20, 6'h24, 6'h34};

  function automatic int m_slot(input logic [5:0] dw);
    for (int i = 0; i < 5; i++) if (DWS[i] == dw) return i;
    return -1;
  endfunction

  function automatic bit in_win(input logic [15:0] a, input logic [15:0] b, input int len);
    return (int'(a) >= int'(b)) && (int'(a) < int'(b) + len);
  endfunction

  function automatic logic [2:0] exp_hits(input logic [15:0] a, input logic v);
    logic pm, smb, gpe;
    pm  = v && m[2][0]  && in_win(a, {m[0][15:6], 6'b0}, 64);
    smb = v && m[4][16] && in_win(a, {m[3][15:6], 6'b0}, 64);
    gpe = v && in_win(a, 16'hafe0, 4);
    return {pm, smb, gpe};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgw(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    int s;
    cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    tick();  // decode follows on the second edge
    s = m_slot(dw);
    if (s >= 0) begin
      for (int b = 0; b < 4; b++) if (be[b]) m[s][8*b +: 8] = d[8*b +: 8];
      if (s == 0) m[0][0] = 1'b1;
    end
  endtask

  task automatic rdchk(input string req, input logic [5:0] dw);
    int s;
    cfg_rdw = dw;
    tick();
    s = m_slot(dw);
    chk(req, cfg_rdata, (s >= 0) ? m[s] : 32'h0);
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic v, input logic wr);
    logic [2:0] e;
    io_addr = a; io_valid = v; io_write = wr;
    #1;
    e = exp_hits(a, v);
    chk(req, {29'd0, hit_pm, hit_smb, hit_gpe}, {29'd0, e});
    tick();
    chk("R9", {31'd0, sci_reeval}, {31'd0, v && wr && e[0]});
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic apm(input logic [7:0] d);
    logic es;
    apm_we = 1'b1; apm_data = d;
    tick();
    es = 1'b0;
    if (d == 8'hf1) sci_m = 1'b1;
    else if (d == 8'hf0) sci_m = 1'b0;
    else es = m[1][25];
    chk("R7", {31'd0, sci_en}, {31'd0, sci_m});
    chk("R8", {31'd0, smi_pulse}, {31'd0, es});
    apm_we = 1'b0;
    tick();
    chk("R8", {31'd0, smi_pulse}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] bases [3];
    int unused_seed;
    unused_seed = $urandom(32'd1357);
    m[0] = 32'h0000_0001; m[1] = 32'h0; m[2] = 32'h0;
    m[3] = 32'h0000_b101; m[4] = 32'h0009_0000;
    sci_m = 1'b0;

    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1", {30'd0, sci_en, smi_pulse}, 32'd0);
    for (int i = 0; i < 5; i++) rdchk("R1", DWS[i]);
    rdchk("R1", 6'h11);

    // reset decode: pm disabled, smb at 0xb100, gpe fixed
    probe("R2", 16'h0000, 1'b1, 1'b0);
    probe("R4", 16'hb100, 1'b1, 1'b0);
    probe("R4", 16'hb13f, 1'b1, 1'b0);
    probe("R4", 16'hb140, 1'b1, 1'b0);
    probe("R6", 16'hafdf, 1'b1, 1'b0);
    probe("R6", 16'hafe0, 1'b1, 1'b0);
    probe("R6", 16'hafe3, 1'b1, 1'b0);
    probe("R6", 16'hafe4, 1'b1, 1'b0);

    // R3 readonly indicator
    cfgw(6'h10, 4'b0011, 32'h0000_c03e);
    rdchk("R3", 6'h10);
    chk("R3", {31'd0, cfg_rdata[0]}, 32'd1);

    // R2 enable and edges
    cfgw(6'h20, 4'b0001, 32'h0000_0001);
    probe("R2", 16'hbfff, 1'b1, 1'b0);
    probe("R2", 16'hc000, 1'b1, 1'b0);
    probe("R2", 16'hc03f, 1'b1, 1'b0);
    probe("R2", 16'hc040, 1'b1, 1'b0);

    // R5 partial writes
    cfgw(6'h10, 4'b0010, 32'h0000_1200);
    rdchk("R5", 6'h10);
    probe("R5", 16'h1200, 1'b1, 1'b0);
    probe("R5", 16'hc000, 1'b1, 1'b0);
    cfgw(6'h20, 4'b0010, 32'h0000_ff00);  // byte 0x81 only
    probe("R5", 16'h123f, 1'b1, 1'b0);
    cfgw(6'h11, 4'b1111, 32'hffff_ffff);  // unimplemented dword
    rdchk("R5", 6'h11);
    probe("R5", 16'h1200, 1'b1, 1'b0);

    // R2 disable
    cfgw(6'h20, 4'b0001, 32'h0000_0000);
    probe("R2", 16'h1200, 1'b1, 1'b0);

    // R4 relocate and disable
    cfgw(6'h24, 4'b0011, 32'h0000_4481);
    probe("R4", 16'h447f, 1'b1, 1'b0);
    probe("R4", 16'h4480, 1'b1, 1'b0);
    probe("R4", 16'h44bf, 1'b1, 1'b0);
    probe("R4", 16'h44c0, 1'b1, 1'b0);
    probe("R4", 16'hb100, 1'b1, 1'b0);
    cfgw(6'h34, 4'b0100, 32'h0008_0000);
    probe("R4", 16'h4480, 1'b1, 1'b0);
    cfgw(6'h34, 4'b0100, 32'h0001_0000);
    probe("R4", 16'h4490, 1'b1, 1'b0);

    // R10 valid low
    probe("R10", 16'h4490, 1'b0, 1'b1);
    probe("R10", 16'hafe1, 1'b0, 1'b1);

    // R9 gpe write vs read
    probe("R9", 16'hafe2, 1'b1, 1'b1);
    probe("R9", 16'hafe2, 1'b1, 1'b0);
    probe("R9", 16'hafe4, 1'b1, 1'b1);

    // R7 / R8 APM classes
    apm(8'hf1);
    apm(8'h55);
    cfgw(6'h16, 4'b1000, 32'h0200_0000);
    apm(8'h55);
    apm(8'hf0);
    apm(8'hf1);
    apm(8'h00);
    cfgw(6'h16, 4'b1000, 32'h0000_0000);
    apm(8'hff);

    // constrained random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [5:0] dw;
          dw = ($urandom_range(0, 5) == 5) ? 6'($urandom()) : DWS[$urandom_range(0, 4)];
          cfgw(dw, 4'($urandom()), $urandom());
          rdchk("R5", dw);
        end
        1, 2: begin
          bases[0] = {m[0][15:6], 6'b0};
          bases[1] = {m[3][15:6], 6'b0};
          bases[2] = 16'hafe0;
          if ($urandom_range(0, 3) == 0) a = 16'($urandom());
          else a = bases[$urandom_range(0, 2)] + 16'($urandom_range(0, 68)) - 16'd2;
          probe("R2", a, 1'($urandom_range(0, 4) != 0), 1'($urandom()));
        end
        default: begin
          int k;
          k = $urandom_range(0, 2);
          apm((k == 0) ? 8'hf0 : (k == 1) ? 8'hf1 : 8'($urandom()));
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule